// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a simple host port and a four-bank single-data-rate SDRAM with a 32-bit data bus. After reset it runs the power-up sequence and programs the device's mode word. It then turns each host request into the shortest legal series of device commands. A request names a bank, a row, a column, a direction, write data and an auto-close flag. Every access moves one 32-bit word.

The sequencer remembers which row is open in each bank. A request to an already open row goes straight to the column command. A request to a different row first closes that one bank. A request to a closed bank first opens the row. Cycle counters hold the device-required gaps between commands. A periodic timer raises refresh work, and that work is done between host transactions, ahead of any new request. Read data is captured after the programmed CAS latency and returned on a one-cycle valid strobe.

Top module: `sdr_cmd_sequencer`

## Requirements
- R1: While reset is high, chip select is high, clock enable is low, `req_ready` is low and `rd_valid` is low.
- R2: After reset, at least INIT_WAIT NOP cycles are driven. Then come a PRECHARGE with address bit 10 high, two AUTO REFRESH commands and one LOAD MODE. `req_ready` stays low until that sequence ends.
- R3: The LOAD MODE address word has bits 2:0 = 000 (one-word bursts), bit 3 = BURST_INTERLEAVE, bits 6:4 = CAS_LAT and all other bits 0. The bank lines are 0.
- R4: Commands on {RAS#,CAS#,WE#} with CS# low are: 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 AUTO REFRESH, 000 LOAD MODE and 111 NOP.
- R5: READ and WRITE are issued only to a bank whose open row equals the request row. A request that hits the open row issues no new ACTIVE.
- R6: A request to a bank whose open row differs is preceded by a PRECHARGE with address bit 10 low, carrying that bank on the bank lines. The following ACTIVE comes no earlier than T_RP cycles later.
- R7: A READ or WRITE comes at least T_RCD cycles after the ACTIVE of its bank. No command follows AUTO REFRESH by fewer than T_RFC cycles, or LOAD MODE by fewer than T_MRD cycles.
- R8: `rd_valid` pulses for one cycle and rises on the CAS_LAT-th clock edge after the edge at which the device registers the READ. `rd_data` then holds the DQ value sampled on that edge.
- R9: With `req_autopre` set, the READ or WRITE carries address bit 10 high, with the column on address bits 7:0. That bank then counts as closed, so its next access issues ACTIVE and no PRECHARGE.
- R10: A refresh falls due every REFRESH_INTERVAL cycles. AUTO REFRESH is issued only when all banks are idle, after a PRECHARGE with bit 10 high if any bank is open. A due refresh is served before a new host request.
- R11: `sd_dq_oe` is high only in the cycle that carries a WRITE, and it drives the request data. DQM is all zero outside reset.
- R12: A request transfers on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all device signals change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the bank after this access |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Target row |
| req_col | input | 8 | Target column |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | One-cycle strobe for returned read data |
| rd_data | output | 32 | Returned read data |
| sd_cke | output | 1 | Device clock enable |
| sd_cs_n | output | 1 | Device chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Multiplexed address |
| sd_dqm | output | 4 | Byte masks |
| sd_dq_out | output | 32 | Data driven to the device |
| sd_dq_oe | output | 1 | Output enable for sd_dq_out |
| sd_dq_in | input | 32 | Data returned by the device |

## Verification
A stale entry in the open-row table shows up at the pins in one of two ways. It may cause a column command to a closed or wrong row within the same transaction. It may also cause a missing or spurious ACTIVE or PRECHARGE, which a command-level responder sees on the next access to that bank. A wrong gap counter shows up on the very next command as a gap shorter than the device minimum. A slip in the latency pipeline moves `rd_valid` by whole cycles on the first read, and it returns data from the wrong slot. Refresh mistakes appear within one refresh interval, either as AUTO REFRESH with a bank still open or as no refresh at all.

// File: rtl/sdr_ctrl_pkg.sv
package sdr_ctrl_pkg;
  // {RAS#, CAS#, WE#} with CS# low
  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR, ST_IREF1, ST_IREF2, ST_IMRS, ST_IDLE, ST_ROW
  } sdr_state_e;
endpackage

// File: rtl/sdr_row_tracker.sv
module sdr_row_tracker #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              close_one,
  input  logic              close_all,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  output logic              hit,
  output logic              bank_open,
  output logic              any_open
);
  localparam int NB = 1 << BANK_W;

  logic [NB-1:0]    open_q;
  logic [ROW_W-1:0] row_q [NB];

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (close_all || (close_one && bank == BANK_W'(b))) begin
          open_q[b] <= 1'b0;
        end else if (act && bank == BANK_W'(b)) begin
          open_q[b] <= 1'b1;
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < NB; g++) begin : g_row
      always_ff @(posedge clk) begin
        if (act && bank == BANK_W'(g)) row_q[g] <= row;
      end
    end
  endgenerate

  assign bank_open = open_q[bank];
  assign hit       = open_q[bank] && (row_q[bank] == row);
  assign any_open  = |open_q;

  assert_close_all_R10: assert property (@(posedge clk) disable iff (rst)
    close_all |=> !any_open);
endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int INTERVAL = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ack,
  output logic pend
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = en && (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (en) cnt <= tick ? '0 : cnt + 1'b1;
      pend <= (pend && !ack) || tick;
    end
  end

  assert_pend_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack) |=> pend);
endmodule

// File: rtl/sdr_read_capture.sv
module sdr_read_capture #(
  parameter int LAT    = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [LAT-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      rd_valid <= 1'b0;
    end else begin
      sr       <= (sr << 1) | LAT'(issue);
      rd_valid <= sr[LAT-1];
    end
  end

  always_ff @(posedge clk) begin
    if (sr[LAT-1]) rd_data <= dq_in;
  end
endmodule

// File: rtl/sdr_cmd_sequencer.sv
module sdr_cmd_sequencer
  import sdr_ctrl_pkg::*;
#(
  parameter int BANK_W           = 2,
  parameter int ROW_W            = 12,
  parameter int COL_W            = 8,
  parameter int DATA_W           = 32,
  parameter int AP_BIT           = 10,
  parameter int CAS_LAT          = 2,
  parameter int BURST_INTERLEAVE = 0,
  parameter int INIT_WAIT        = 100,
  parameter int T_RCD            = 3,
  parameter int T_RP             = 3,
  parameter int T_RFC            = 10,
  parameter int T_MRD            = 2,
  parameter int REFRESH_INTERVAL = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_autopre,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [DATA_W/8-1:0] sd_dqm,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);
  localparam int MASK_W = DATA_W / 8;
  localparam int CW = $clog2(INIT_WAIT + T_RFC + T_RP + T_RCD + T_MRD + CAS_LAT + 4);
  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'((BURST_INTERLEAVE << 3) | (CAS_LAT << 4));

  sdr_state_e        st, n_st;
  sdr_cmd_e          cmd_q, n_cmd;
  logic [CW-1:0]     cnt, n_cnt;
  logic [BANK_W-1:0] n_ba, bank_q;
  logic [ROW_W-1:0]  n_a, row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q, ap_q, n_oe, n_rd, rd_issue;
  logic              wait_done, accept, ref_pend, ref_ack;
  logic              trk_act, trk_close_one, trk_close_all;
  logic              hit, bank_open, any_open;

  assign wait_done = (cnt == '0);
  assign req_ready = (st == ST_IDLE) && wait_done && !ref_pend;
  assign accept    = req_valid && req_ready;
  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  sdr_row_tracker #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst(rst), .act(trk_act), .close_one(trk_close_one),
    .close_all(trk_close_all), .bank(bank_q), .row(row_q),
    .hit(hit), .bank_open(bank_open), .any_open(any_open));

  sdr_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_refresh (
    .clk(clk), .rst(rst), .en(st == ST_IDLE || st == ST_ROW),
    .ack(ref_ack), .pend(ref_pend));

  sdr_read_capture #(.LAT(CAS_LAT), .DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst(rst), .issue(rd_issue), .dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data));

  always_comb begin
    n_st = st;  n_cmd = CMD_NOP;  n_ba = sd_ba;  n_a = sd_a;
    n_cnt = wait_done ? '0 : cnt - 1'b1;
    n_oe = 1'b0;  n_rd = 1'b0;  ref_ack = 1'b0;
    trk_act = 1'b0;  trk_close_one = 1'b0;  trk_close_all = 1'b0;
    if (wait_done) begin
      unique case (st)
        ST_PWR: begin
          n_cmd = CMD_PRE;  n_a = '0;  n_a[AP_BIT] = 1'b1;
          n_cnt = CW'(T_RP - 1);  n_st = ST_IREF1;  trk_close_all = 1'b1;
        end
        ST_IREF1, ST_IREF2: begin
          n_cmd = CMD_REF;  n_cnt = CW'(T_RFC - 1);
          n_st  = (st == ST_IREF1) ? ST_IREF2 : ST_IMRS;
        end
        ST_IMRS: begin
          n_cmd = CMD_LMR;  n_a = MODE_WORD;  n_ba = '0;
          n_cnt = CW'(T_MRD - 1);  n_st = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend && any_open) begin
            n_cmd = CMD_PRE;  n_a = '0;  n_a[AP_BIT] = 1'b1;
            n_cnt = CW'(T_RP - 1);  trk_close_all = 1'b1;
          end else if (ref_pend) begin
            n_cmd = CMD_REF;  n_cnt = CW'(T_RFC - 1);  ref_ack = 1'b1;
          end else if (req_valid) begin
            n_st = ST_ROW;
          end
        end
        ST_ROW: begin
          n_ba = bank_q;
          if (hit) begin
            n_cmd = wr_q ? CMD_WR : CMD_RD;
            n_a = '0;  n_a[COL_W-1:0] = col_q;  n_a[AP_BIT] = ap_q;
            n_oe = wr_q;  n_rd = !wr_q;  trk_close_one = ap_q;
            if (wr_q) n_cnt = ap_q ? CW'(T_RP + 1) : '0;
            else      n_cnt = ap_q ? CW'(CAS_LAT + T_RP) : CW'(CAS_LAT);
            n_st = ST_IDLE;
          end else if (bank_open) begin
            n_cmd = CMD_PRE;  n_a = '0;
            n_cnt = CW'(T_RP - 1);  trk_close_one = 1'b1;
          end else begin
            n_cmd = CMD_ACT;  n_a = row_q;
            n_cnt = CW'(T_RCD - 1);  trk_act = 1'b1;
          end
        end
        default: n_st = ST_PWR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_PWR;  cnt <= CW'(INIT_WAIT);  cmd_q <= CMD_NOP;
      sd_cs_n <= 1'b1;  sd_cke <= 1'b0;  sd_dqm <= '1;
      sd_ba <= '0;  sd_a <= '0;  sd_dq_oe <= 1'b0;  sd_dq_out <= '0;
      rd_issue <= 1'b0;
    end else begin
      st <= n_st;  cnt <= n_cnt;  cmd_q <= n_cmd;
      sd_cs_n <= 1'b0;  sd_cke <= 1'b1;  sd_dqm <= {MASK_W{1'b0}};
      sd_ba <= n_ba;  sd_a <= n_a;  sd_dq_oe <= n_oe;
      if (n_oe) sd_dq_out <= wdata_q;
      rd_issue <= n_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      bank_q <= req_bank;  row_q <= req_row;  col_q <= req_col;
      wr_q <= req_write;  ap_q <= req_autopre;  wdata_q <= req_wdata;
    end
  end

  assert_oe_only_write_R11: assert property (@(posedge clk) disable iff (rst)
    sd_dq_oe |-> (cmd_q == CMD_WR) && (sd_dqm == '0));
  assert_refresh_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_REF) |-> !any_open);
  assert_rw_open_bank_R5: assert property (@(posedge clk) disable iff (rst)
    ((cmd_q == CMD_RD || cmd_q == CMD_WR) && !sd_a[AP_BIT]) |-> bank_open);
  assert_rd_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  assert_ready_drops_R12: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);
endmodule

// File: tb/sdr_cmd_sequencer_test.sv
module sdr_cmd_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CL = 3, BT = 1, INIT_W = 20;
  localparam int TRCD = 2, TRP = 2, TRFC = 6, TMRD = 2, REFI = 150;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_autopre = 0, req_ready;
  logic [1:0] req_bank = 0;  logic [11:0] req_row = 0;
  logic [7:0] req_col = 0;   logic [31:0] req_wdata = 0;
  logic rd_valid;  logic [31:0] rd_data;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba;  logic [11:0] sd_a;  logic [3:0] sd_dqm;
  logic [31:0] sd_dq_out, sd_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_cmd_sequencer #(.CAS_LAT(CL), .BURST_INTERLEAVE(BT), .INIT_WAIT(INIT_W),
    .T_RCD(TRCD), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
    .REFRESH_INTERVAL(REFI)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_autopre(req_autopre), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in));

  int checks = 0, errors = 0;
  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- command-level responder ----------------
  logic [31:0] mem [int];
  logic [31:0] pipe [CL];
  bit          open_b [4];
  logic [11:0] orow [4];
  longint last_pre [4], last_act [4];
  longint cyc = 0, last_ref = -1000, last_lmr = -1000, rd_cyc = 0;
  int viol = 0, n_act = 0, n_pre1 = 0, n_preall = 0, n_ref = 0, n_cmd = 0, nop_before = 0;
  logic [2:0] log_cmd [4];
  logic       log_a10 [4];
  logic [11:0] lmr_a = '0;
  logic [2:0] rc;
  int key;

  assign sd_dq_in = pipe[CL-1];

  task automatic note(string s);
    viol++;
    $display("protocol violation at cycle %0d: %s", cyc, s);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      open_b[i] = 0; last_pre[i] = -1000; last_act[i] = -1000; orow[i] = '0;
    end
    for (int i = 0; i < CL; i++) pipe[i] = '0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int i = CL-1; i > 0; i--) pipe[i] <= pipe[i-1];
    pipe[0] <= '0;
    rc = {sd_ras_n, sd_cas_n, sd_we_n};
    if (!rst && !sd_cs_n) begin
      if (rc != 3'b111) begin
        if (n_cmd < 4) begin log_cmd[n_cmd] = rc; log_a10[n_cmd] = sd_a[10]; end
        n_cmd++;
        if (cyc - last_ref < TRFC) note("command too soon after refresh (R7)");
        if (cyc - last_lmr < TMRD) note("command too soon after mode load (R7)");
      end else if (n_cmd == 0) nop_before++;
      if (sd_dq_oe && rc != 3'b100) note("data driven without WRITE (R11)");
      case (rc)
        3'b011: begin
          if (open_b[sd_ba]) note("ACTIVE to open bank (R6)");
          if (cyc - last_pre[sd_ba] < TRP) note("ACTIVE too soon after precharge (R6)");
          open_b[sd_ba] = 1; orow[sd_ba] = sd_a; last_act[sd_ba] = cyc; n_act++;
        end
        3'b101, 3'b100: begin
          if (!open_b[sd_ba]) note("column command to closed bank (R5)");
          if (cyc - last_act[sd_ba] < TRCD) note("column command too soon (R7)");
          key = int'({sd_ba, orow[sd_ba], sd_a[7:0]});
          if (rc == 3'b100) begin
            if (!sd_dq_oe || sd_dqm != 4'h0) note("write data not driven (R11)");
            mem[key] = sd_dq_out;
          end else begin
            pipe[0] <= mem.exists(key) ? mem[key] : 32'hBAD0_0000;
            rd_cyc = cyc;
          end
          if (sd_a[10]) begin open_b[sd_ba] = 0; last_pre[sd_ba] = cyc; end
        end
        3'b010: begin
          if (sd_a[10]) begin
            for (int i = 0; i < 4; i++) begin open_b[i] = 0; last_pre[i] = cyc; end
            n_preall++;
          end else begin
            open_b[sd_ba] = 0; last_pre[sd_ba] = cyc; n_pre1++;
          end
        end
        3'b001: begin
          for (int i = 0; i < 4; i++) begin
            if (open_b[i]) note("refresh with open bank (R10)");
            if (cyc - last_pre[i] < TRP) note("refresh too soon after precharge (R10)");
          end
          last_ref = cyc; n_ref++;
        end
        3'b000: begin
          for (int i = 0; i < 4; i++) if (open_b[i]) note("mode load with open bank (R2)");
          lmr_a = sd_a; last_lmr = cyc;
        end
        default: ;
      endcase
    end
  end

  // ---------------- host tasks ----------------
  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_req(bit wr, bit ap, logic [1:0] b, logic [11:0] r,
                        logic [7:0] c, logic [31:0] d);
    int guard = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_autopre = ap;
    req_bank = b; req_row = r; req_col = c; req_wdata = d;
    while (!req_ready && guard < 500) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 1'b0, "R12", "ready after accept", req_ready, 0);
  endtask

  task automatic read_word(bit ap, logic [1:0] b, logic [11:0] r, logic [7:0] c,
                           output logic [31:0] d, output longint lat);
    int guard = 0;
    do_req(0, ap, b, r, c, 32'h0);
    while (!rd_valid && guard < 100) begin @(negedge clk); guard++; end
    d = rd_data;
    lat = cyc - rd_cyc;
    @(negedge clk);
    check(rd_valid == 1'b0, "R8", "rd_valid single pulse", rd_valid, 0);
  endtask

  task automatic sync_refresh();
    int start = n_ref, guard = 0;
    while (n_ref == start && guard < 2*REFI) begin @(negedge clk); guard++; end
    repeat (TRFC + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(sd_cs_n == 1'b1, "R1", "cs_n in reset", sd_cs_n, 1);
    check(sd_cke == 1'b0, "R1", "cke in reset", sd_cke, 0);
    check(req_ready == 1'b0, "R1", "ready in reset", req_ready, 0);
    check(rd_valid == 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
  endtask

  task automatic t_init();
    int guard = 0;
    rst = 0;
    while (!req_ready && guard < 500) begin @(negedge clk); guard++; end
    check(nop_before >= INIT_W, "R2", "NOP cycles before first command", nop_before, INIT_W);
    check(log_cmd[0] == 3'b010 && log_a10[0], "R2", "first command precharge all",
          {log_cmd[0], log_a10[0]}, 4'b0101);
    check(log_cmd[1] == 3'b001 && log_cmd[2] == 3'b001, "R4", "two refresh commands",
          {log_cmd[1], log_cmd[2]}, 6'b001001);
    check(log_cmd[3] == 3'b000, "R2", "mode load last", log_cmd[3], 0);
    check(lmr_a == 12'((BT << 3) | (CL << 4)), "R3", "mode word", lmr_a, (BT << 3) | (CL << 4));
  endtask

  task automatic t_hit();
    logic [31:0] d; longint lat; int a0;
    sync_refresh();
    a0 = n_act;
    do_req(1, 0, 2'd0, 12'd5, 8'd3, 32'hA5A5_0001);
    read_word(0, 2'd0, 12'd5, 8'd3, d, lat);
    check(d == 32'hA5A5_0001, "R11", "read back written word", d, 32'hA5A5_0001);
    check(lat == CL + 1, "R8", "latency (bench counter offset one)", lat, CL + 1);
    check(n_act - a0 == 1, "R5", "open row reused without ACTIVE", n_act - a0, 1);
  endtask

  task automatic t_miss();
    logic [31:0] d; longint lat; int p0;
    sync_refresh();
    do_req(1, 0, 2'd0, 12'd5, 8'd3, 32'hA5A5_0001);
    p0 = n_pre1;
    do_req(1, 0, 2'd0, 12'd9, 8'd3, 32'h0000_B002);
    read_word(0, 2'd0, 12'd5, 8'd3, d, lat);
    check(n_pre1 - p0 == 2, "R6", "single-bank precharge per row miss", n_pre1 - p0, 2);
    check(d == 32'hA5A5_0001, "R6", "data after row switch", d, 32'hA5A5_0001);
    read_word(0, 2'd0, 12'd9, 8'd3, d, lat);
    check(d == 32'h0000_B002, "R6", "second row data", d, 32'h0000_B002);
  endtask

  task automatic t_autopre();
    logic [31:0] d; longint lat; int a0, p0;
    sync_refresh();
    a0 = n_act; p0 = n_pre1;
    do_req(1, 1, 2'd2, 12'd7, 8'd1, 32'hC0DE_0003);
    read_word(0, 2'd2, 12'd7, 8'd1, d, lat);
    check(n_act - a0 == 2, "R9", "ACTIVE again after auto close", n_act - a0, 2);
    check(n_pre1 == p0, "R9", "no explicit precharge", n_pre1 - p0, 0);
    check(d == 32'hC0DE_0003, "R9", "data after auto close", d, 32'hC0DE_0003);
  endtask

  task automatic t_banks();
    logic [31:0] d; longint lat;
    sync_refresh();
    do_req(1, 0, 2'd1, 12'd100, 8'd10, 32'h1111_0001);
    do_req(1, 0, 2'd3, 12'd200, 8'd20, 32'h3333_0003);
    read_word(0, 2'd1, 12'd100, 8'd10, d, lat);
    check(d == 32'h1111_0001, "R5", "bank 1 data", d, 32'h1111_0001);
    read_word(1, 2'd3, 12'd200, 8'd20, d, lat);
    check(d == 32'h3333_0003, "R5", "bank 3 data", d, 32'h3333_0003);
  endtask

  task automatic t_refresh();
    int pa0, r0;
    do_req(1, 0, 2'd1, 12'd44, 8'd4, 32'h0404_0404);
    pa0 = n_preall; r0 = n_ref;
    repeat (2*REFI) @(negedge clk);
    check(n_ref - r0 >= 1, "R10", "refresh count in two intervals", n_ref - r0, 1);
    check(n_preall - pa0 >= 1, "R10", "precharge all before refresh", n_preall - pa0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(0, "WATCHDOG", "run timed out", 0, 1);
    finish_run();
  end

  initial begin
    t_reset();
    t_init();
    t_hit();
    t_miss();
    t_autopre();
    t_banks();
    t_refresh();
    check(viol == 0, "R7", "responder protocol violations (R4 R5 R7 R11)", viol, 0);
    finish_run();
  end
endmodule